// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block produces the channel and gain selection for a converter front end that sits behind an eight-way analog multiplexer. A host sets it up through a small byte-wide write port. A command byte carries the end channel, a gain code and a scan flag. A mode byte picks the scan direction and turns on interval grouping. Two more write codes set and arm an interval count. The converter is paced from outside, and each pacing pulse on `conv_i` consumes the channel currently on `chan_o`. The sequencer then moves to the next channel of the scan.

With scanning off, every conversion uses the programmed channel. With scanning on, the default order runs from the programmed channel down to channel 0. The upward mode runs from channel 0 up to the programmed channel. In both orders the sequence wraps and repeats. A one-cycle end-of-scan strobe follows the conversion on the last channel. A one-cycle scan-start strobe follows the conversion on the first channel. In interval mode the scan-start strobe fires only once per group of scans, and the group size is set by the programmed count.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `chan_o` and `gain_o` read 0 and both strobes are low. Scanning is off and both the direction bit and the interval bit are clear.
- R2: A command write (`wr_sel_i`=0) takes the channel from data bits [2:0] and the gain from bits [6:4], and ignores bit 3. The new channel and gain appear on the outputs in the cycle after the write.
- R3: While scanning is off (bit 7 of the last command clear, or scanning not yet armed), every accepted conversion keeps `chan_o` at the programmed channel. Each such conversion raises `eos_o`, and also `scan_start_o` when interval mode is off.
- R4: A command write with bit 7 set turns scanning on only if an earlier command write since reset had bit 7 clear. Otherwise the fields are stored and scanning stays off.
- R5: With scanning on and mode bit 7 clear, the channel starts at the programmed value and steps down by one per accepted conversion to channel 0. The next conversion then wraps it back to the programmed value.
- R6: With scanning on and mode bit 7 set (`wr_sel_i`=1), the channel starts at 0 and steps up by one per accepted conversion to the programmed value. The next conversion then wraps it back to 0.
- R7: `eos_o` is high for exactly the cycle after an accepted conversion on the last channel of a scan. `scan_start_o` is high for exactly the cycle after an accepted conversion on the first channel, subject to R10.
- R8: A command or mode write returns the channel counter to the start channel of the new settings, even in the middle of a scan.
- R9: `gain_o` changes only after a command write, so one gain code covers a whole scan.
- R10: With mode bit 0 set, `scan_start_o` fires on the first scan after a restart or a load, and then on every K-th scan. K is the count byte written with `wr_sel_i`=2 and copied in by a write with `wr_sel_i`=3. K=1 gives a strobe on every scan.
- R11: A conversion pulse in the same cycle as any write is ignored, so neither strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 command, 1 mode, 2 interval count, 3 interval load |
| wr_data_i | input | 8 | Write data |
| conv_i | input | 1 | Conversion pulse; consumes the presented channel |
| chan_o | output | 3 | Channel select for the multiplexer |
| gain_o | output | 3 | Gain code for the whole scan |
| scan_start_o | output | 1 | One-cycle pulse after the first conversion of a scan or interval group |
| eos_o | output | 1 | One-cycle pulse after the last conversion of a scan |

## Verification
The assertions assume that `conv_i` and the write port are known and synchronous to `clk_i` once reset has been released. They also assume that the output registers report only conversions that were accepted, and not the raw pulse. The stimulus drives every input on the falling edge, and it changes the write port and `conv_i` together in only one deliberate collision case. As a result, each strobe can be traced back to a single accepted pulse. The wrap points, the direction change in the middle of a scan and the interval grouping are all reached through the write port alone.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int DATA_W       = 8;
  localparam int CHAN_W       = 3;
  localparam int GAIN_W       = 3;
  localparam int IVAL_W       = 8;
  localparam int CMD_SCAN_BIT = 7;
  localparam int CMD_GAIN_LSB = 4;
  localparam int MODE_UP_BIT  = 7;
  localparam int MODE_IV_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_IVCNT  = 2'd2,
    SEL_IVLOAD = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic              scan_en;
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] top;
    logic              up;
    logic              iv_en;
  } scan_cfg_t;
endpackage

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output scan_cfg_t         cfg_o,
  output logic              restart_o
);
  scan_cfg_t cfg_q;
  logic      armed_q;
  logic      cmd_wr, mode_wr;
  logic      unused_bits;

  assign cmd_wr      = wr_en_i && (wr_sel_i == SEL_CMD);
  assign mode_wr     = wr_en_i && (wr_sel_i == SEL_MODE);
  assign unused_bits = ^{wr_data_i[3], wr_data_i[6:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cfg_q.top  <= wr_data_i[CHAN_W-1:0];
        cfg_q.gain <= wr_data_i[CMD_GAIN_LSB +: GAIN_W];
        if (wr_data_i[CMD_SCAN_BIT]) begin
          // enable only after a prior write with scan clear
          cfg_q.scan_en <= armed_q | cfg_q.scan_en;
        end else begin
          cfg_q.scan_en <= 1'b0;
          armed_q       <= 1'b1;
        end
      end
      if (mode_wr) begin
        cfg_q.up    <= wr_data_i[MODE_UP_BIT];
        cfg_q.iv_en <= wr_data_i[MODE_IV_BIT];
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign restart_o = cmd_wr | mode_wr;
endmodule

// File: rtl/scan_chan_ctr.sv
module scan_chan_ctr #(
  parameter int CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic              scan_en_i,
  input  logic              up_i,
  input  logic [CHAN_W-1:0] top_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              first_o,
  output logic              last_o
);
  // idx_q counts steps taken from the start channel, in either direction
  logic [CHAN_W-1:0] idx_q;

  assign first_o = (idx_q == '0);
  assign last_o  = !scan_en_i || (idx_q == top_i);

  always_comb begin
    if (!scan_en_i)  chan_o = top_i;
    else if (up_i)   chan_o = idx_q;
    else             chan_o = top_i - idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (restart_i) idx_q <= '0;
    else if (step_i)    idx_q <= last_o ? '0 : idx_q + CHAN_W'(1);
  end
endmodule

// File: rtl/scan_interval.sv
module scan_interval #(
  parameter int IVAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic              load_i,
  input  logic              restart_i,
  input  logic [IVAL_W-1:0] data_i,
  input  logic              en_i,
  input  logic              begin_i,
  output logic              fire_o
);
  logic [IVAL_W-1:0] cnt_q, reload_q, left_q;

  assign fire_o = !en_i || (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= IVAL_W'(1);
      reload_q <= IVAL_W'(1);
      left_q   <= '0;
    end else begin
      if (cnt_wr_i) cnt_q <= data_i;
      if (load_i) begin
        reload_q <= cnt_q;
        left_q   <= '0;
      end else if (restart_i) begin
        left_q <= '0;
      end else if (begin_i && en_i) begin
        left_q <= fire_o ? reload_q - IVAL_W'(1) : left_q - IVAL_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              conv_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              scan_start_o,
  output logic              eos_o
);
  scan_cfg_t         cfg;
  logic              restart, accept, first, last, fire;
  logic              iv_cnt_wr, iv_load;
  logic              eos_q, start_q;
  logic [CHAN_W-1:0] top_chan;

  // writes take priority over a coincident conversion pulse
  assign accept    = conv_i && !wr_en_i;
  assign iv_cnt_wr = wr_en_i && (wr_sel_i == SEL_IVCNT);
  assign iv_load   = wr_en_i && (wr_sel_i == SEL_IVLOAD);
  assign top_chan  = cfg.top;

  scan_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  scan_chan_ctr #(.CHAN_W(CHAN_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (accept),
    .scan_en_i (cfg.scan_en),
    .up_i      (cfg.up),
    .top_i     (cfg.top),
    .chan_o    (chan_o),
    .first_o   (first),
    .last_o    (last)
  );

  scan_interval #(.IVAL_W(IVAL_W)) u_ival (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_wr_i  (iv_cnt_wr),
    .load_i    (iv_load),
    .restart_i (restart),
    .data_i    (wr_data_i[IVAL_W-1:0]),
    .en_i      (cfg.iv_en),
    .begin_i   (accept && first),
    .fire_o    (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eos_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      eos_q   <= accept && last;
      start_q <= accept && first && fire;
    end
  end

  assign gain_o       = cfg.gain;
  assign eos_o        = eos_q;
  assign scan_start_o = start_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CHAN_W = 3,
  parameter int GAIN_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              conv_i,
  input logic [CHAN_W-1:0] chan_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic              eos_o,
  input logic              scan_start_o,
  input logic [CHAN_W-1:0] top_i
);
  // R7
  eos_needs_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> $past(conv_i));
  // R7
  start_needs_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_start_o |-> $past(conv_i));
  // R11
  write_blocks_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> (!eos_o && !scan_start_o));
  // R9
  gain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(gain_o));
  // R3
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && !$past(conv_i)) |-> $stable(chan_o));
  // R5
  chan_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_o <= top_i);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .conv_i       (conv_i),
  .chan_o       (chan_o),
  .gain_o       (gain_o),
  .eos_o        (eos_o),
  .scan_start_o (scan_start_o),
  .top_i        (top_chan)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  typedef struct packed {
    logic       we;
    logic [1:0] sel;
    logic [7:0] d;
    logic       cv;
    logic [2:0] ch;
    logic [2:0] g;
    logic       eos;
    logic       st;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0,2'd0,8'h00,1'b1,3'd0,3'd0,1'b1,1'b1,4'd3},  // R3 reset config, single ch 0
    '{1'b1,2'd0,8'h35,1'b0,3'd5,3'd3,1'b0,1'b0,4'd2},  // R2
    '{1'b0,2'd0,8'h00,1'b1,3'd5,3'd3,1'b1,1'b1,4'd3},  // R3
    '{1'b0,2'd0,8'h00,1'b1,3'd5,3'd3,1'b1,1'b1,4'd3},  // R3
    '{1'b1,2'd0,8'hB5,1'b0,3'd5,3'd3,1'b0,1'b0,4'd4},  // R4 armed enable
    '{1'b0,2'd0,8'h00,1'b1,3'd4,3'd3,1'b0,1'b1,4'd5},  // R5
    '{1'b0,2'd0,8'h00,1'b1,3'd3,3'd3,1'b0,1'b0,4'd5},
    '{1'b0,2'd0,8'h00,1'b1,3'd2,3'd3,1'b0,1'b0,4'd5},
    '{1'b0,2'd0,8'h00,1'b1,3'd1,3'd3,1'b0,1'b0,4'd5},
    '{1'b0,2'd0,8'h00,1'b1,3'd0,3'd3,1'b0,1'b0,4'd5},
    '{1'b0,2'd0,8'h00,1'b1,3'd5,3'd3,1'b1,1'b0,4'd7},  // R7 wrap + eos
    '{1'b0,2'd0,8'h00,1'b1,3'd4,3'd3,1'b0,1'b1,4'd7},  // R7 start
    '{1'b0,2'd0,8'h00,1'b0,3'd4,3'd3,1'b0,1'b0,4'd9},  // R9 idle hold
    '{1'b1,2'd0,8'hA2,1'b0,3'd2,3'd2,1'b0,1'b0,4'd8},  // R8 mid-scan rewrite
    '{1'b1,2'd1,8'h80,1'b1,3'd0,3'd2,1'b0,1'b0,4'd11}, // R11 write+conv, up
    '{1'b0,2'd0,8'h00,1'b1,3'd1,3'd2,1'b0,1'b1,4'd6},  // R6
    '{1'b0,2'd0,8'h00,1'b1,3'd2,3'd2,1'b0,1'b0,4'd6},
    '{1'b0,2'd0,8'h00,1'b1,3'd0,3'd2,1'b1,1'b0,4'd6},  // R6 wrap
    '{1'b1,2'd0,8'h13,1'b0,3'd3,3'd1,1'b0,1'b0,4'd3},
    '{1'b0,2'd0,8'h00,1'b1,3'd3,3'd1,1'b1,1'b1,4'd3},
    '{1'b1,2'd0,8'h93,1'b0,3'd0,3'd1,1'b0,1'b0,4'd6},
    '{1'b1,2'd2,8'h02,1'b0,3'd0,3'd1,1'b0,1'b0,4'd10}, // R10 count
    '{1'b1,2'd3,8'h00,1'b0,3'd0,3'd1,1'b0,1'b0,4'd10}, // R10 load
    '{1'b1,2'd1,8'h81,1'b0,3'd0,3'd1,1'b0,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd1,3'd1,1'b0,1'b1,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd2,3'd1,1'b0,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd3,3'd1,1'b0,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd0,3'd1,1'b1,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd1,3'd1,1'b0,1'b0,4'd10}, // R10 skipped start
    '{1'b0,2'd0,8'h00,1'b1,3'd2,3'd1,1'b0,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd3,3'd1,1'b0,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd0,3'd1,1'b1,1'b0,4'd10},
    '{1'b0,2'd0,8'h00,1'b1,3'd1,3'd1,1'b0,1'b1,4'd10},
    '{1'b1,2'd1,8'h01,1'b0,3'd3,3'd1,1'b0,1'b0,4'd8},  // R8 direction flip
    '{1'b0,2'd0,8'h00,1'b1,3'd2,3'd1,1'b0,1'b1,4'd10}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       conv_i = 1'b0;
  logic [2:0] chan_o, gain_o;
  logic       scan_start_o, eos_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_scan_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .conv_i(conv_i), .chan_o(chan_o), .gain_o(gain_o),
    .scan_start_o(scan_start_o), .eos_o(eos_o)
  );

  task automatic check(input int req, input logic [2:0] ch, input logic [2:0] g,
                       input logic eos, input logic st);
    n_chk++;
    if ({chan_o, gain_o, eos_o, scan_start_o} !== {ch, g, eos, st}) begin
      n_bad++;
      $display("FAIL R%0d: got ch=%0d g=%0d eos=%b st=%b, expected ch=%0d g=%0d eos=%b st=%b",
               req, chan_o, gain_o, eos_o, scan_start_o, ch, g, eos, st);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus
  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] d,
                      input logic cv);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; conv_i = cv;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; conv_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, 3'd0, 3'd0, 1'b0, 1'b0);  // R1 in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 3'd0, 3'd0, 1'b0, 1'b0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].sel, VEC[i].d, VEC[i].cv);
      check(int'(VEC[i].req), VEC[i].ch, VEC[i].g, VEC[i].eos, VEC[i].st);
    end

    // R1: reset mid-run clears everything
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 3'd0, 3'd0, 1'b0, 1'b0);

    // R4: enable without a prior scan-clear write stays single channel
    step(1'b1, 2'd0, 8'h84, 1'b0);
    check(4, 3'd4, 3'd0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check(4, 3'd4, 3'd0, 1'b1, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check(4, 3'd4, 3'd0, 1'b1, 1'b1);

    // R2: bit 3 ignored
    step(1'b1, 2'd0, 8'h6E, 1'b0);
    check(2, 3'd6, 3'd6, 1'b0, 1'b0);
    // R5: now armed, enable and step down
    step(1'b1, 2'd0, 8'hEE, 1'b0);
    check(5, 3'd6, 3'd6, 1'b0, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check(5, 3'd5, 3'd6, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule